// File: doc/BRIEF.md
# DDS Parallel Profile Write Sequencer

This block drives the parallel control port of a direct digital synthesizer. A requester offers a frequency word, a combined amplitude/phase word and a mode bit. The block turns them into a short series of bus words. Each word carries a 4-bit function select, a data field and an update strobe. Each word is held for a fixed number of system clocks before the next one appears.

The receiving device samples the port on its own clock, which runs much faster than the words change and is not related to them. The sequence is therefore built so that the device never latches a function select together with data meant for another select. It also never sees the update strobe before the data it commits has settled.

There are two modes:
- **Fast mode** uses two words: a frequency word, then an amplitude/phase word with the strobe set.
- **Staged mode** uses four words. It changes the select lines, the data lines and the strobe in separate words.

Top module: `dds_par_seq`

## Requirements
- R1: After reset, bus_fsel is 4'b0000, bus_data is zero, bus_update is 0, done is 0, busy is 0 and req_ready is 1.
- R2: With req_mode = 0 (fast), the block emits two words in order. The first is (fsel 4'b0010, the frequency word, update 0). The second is (fsel 4'b0101, the amplitude/phase word, update 1).
- R3: With req_mode = 1 (staged), the block emits four words in order:
  - (4'b0010, frequency word, 0)
  - (4'b0101, frequency word, 0)
  - (4'b0101, amplitude/phase word, 0)
  - (4'b0101, amplitude/phase word, 1)
- R4: Each word is presented for exactly HOLD_CYCLES clocks. The first word appears in the cycle after acceptance.
- R5: bus_update is high for exactly one word period per accepted request. In staged mode it rises only while bus_fsel and bus_data keep their values from the previous word.
- R6: busy is high and req_ready low from the cycle after acceptance until the last word's hold time expires, which is 2·HOLD_CYCLES or 4·HOLD_CYCLES cycles.
- R7: A request held valid while the block is busy is not lost. It is accepted in the first cycle req_ready is high, and its words follow directly.
- R8: req_mode, req_freq and req_ampph are captured at acceptance. Changing them during a sequence has no effect on the words of that sequence.
- R9: While idle, bus_fsel and bus_data keep the last word's values and bus_update stays 0.
- R10: done is high for exactly one cycle: the cycle right after the update word's period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Change request offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_mode | input | 1 | 0 = fast two-word, 1 = staged four-word |
| req_freq | input | DATA_W | Frequency word |
| req_ampph | input | DATA_W | Combined amplitude/phase word |
| bus_fsel | output | 4 | Function select lines to the synthesizer |
| bus_data | output | DATA_W | Data lines to the synthesizer |
| bus_update | output | 1 | Update strobe to the synthesizer |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The assertions cover behaviour that must hold on every cycle:
- the hold counter stays in range;
- the strobe is only set while busy, and the bus lines stay steady while it is set;
- in staged mode the strobe rises only on lines that are already stable;
- the bus is quiet while idle;
- the captured mode is frozen during a sequence;
- done never lasts two cycles.

Only the bench's scenarios can show the rest:
- the exact word order and its values in each mode;
- the precise hold length of every word;
- that changing the inputs mid-sequence leaves the words untouched;
- that a request held off during a busy period comes out intact right after.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam logic [3:0] FSEL_NONE  = 4'b0000;
    localparam logic [3:0] FSEL_FREQ  = 4'b0010;
    localparam logic [3:0] FSEL_AMPPH = 4'b0101;

    typedef enum logic {
        SEQ_FAST   = 1'b0,
        SEQ_STAGED = 1'b1
    } seq_mode_e;

    // Control part of one bus word; the data itself is chosen by use_ampph.
    typedef struct packed {
        logic [3:0] fsel;
        logic       use_ampph;
        logic       upd;
    } word_ctl_t;

    function automatic logic [1:0] last_step(seq_mode_e m);
        return (m == SEQ_STAGED) ? 2'd3 : 2'd1;
    endfunction

    function automatic word_ctl_t step_ctl(seq_mode_e m, logic [1:0] s);
        word_ctl_t c;
        c.fsel      = FSEL_AMPPH;
        c.use_ampph = 1'b1;
        c.upd       = 1'b0;
        if (m == SEQ_FAST) begin
            if (s == 2'd0) begin
                c.fsel      = FSEL_FREQ;
                c.use_ampph = 1'b0;
            end else begin
                c.upd = 1'b1;
            end
        end else begin
            case (s)
                2'd0: begin
                    c.fsel      = FSEL_FREQ;
                    c.use_ampph = 1'b0;
                end
                2'd1: c.use_ampph = 1'b0;   // new select, old data
                2'd2: c.use_ampph = 1'b1;   // new data, no strobe yet
                default: c.upd = 1'b1;      // same word plus strobe
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/dps_hold_timer.sv
module dps_hold_timer #(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = run && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    // R4: the count never passes the last hold cycle
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST);

endmodule

// File: rtl/dps_step_fsm.sv
module dps_step_fsm
    import dps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_mode,
    input  logic       hold_expire,
    output logic       accept,
    output logic       advance,
    output logic       finish,
    output logic       busy,
    output seq_mode_e  mode_q,
    output logic [1:0] step,
    output logic       done
);
    logic at_last;

    assign at_last = (step == last_step(mode_q));
    assign accept  = req_valid && !busy;
    assign advance = busy && hold_expire && !at_last;
    assign finish  = busy && hold_expire && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            step   <= 2'd0;
            mode_q <= SEQ_FAST;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                busy   <= 1'b1;
                step   <= 2'd0;
                mode_q <= seq_mode_e'(req_mode);
            end else if (advance) begin
                step <= step + 2'd1;
            end else if (finish) begin
                busy <= 1'b0;
            end
        end
    end

    // R8: captured mode cannot move during a running sequence
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode_q));

    // R10: completion pulse lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: the step never runs beyond the mode's last word
    a_r6_step_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step <= last_step(mode_q)));

endmodule

// File: rtl/dps_word_reg.sv
module dps_word_reg
    import dps_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clear_upd,
    input  word_ctl_t         ctl,
    input  logic [DATA_W-1:0] freq_src,
    input  logic [DATA_W-1:0] ampph_src,
    output logic [3:0]        fsel,
    output logic [DATA_W-1:0] data,
    output logic              upd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fsel <= FSEL_NONE;
            data <= '0;
            upd  <= 1'b0;
        end else if (load) begin
            fsel <= ctl.fsel;
            data <= ctl.use_ampph ? ampph_src : freq_src;
            upd  <= ctl.upd;
        end else if (clear_upd) begin
            upd <= 1'b0;
        end
    end

    // R5: lines do not move while the strobe stays set
    a_r5_upd_lines_steady: assert property (@(posedge clk) disable iff (rst)
        (upd && $past(upd)) |-> ($stable(fsel) && $stable(data)));

endmodule

// File: rtl/dds_par_seq.sv
module dds_par_seq
    import dps_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int HOLD_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_mode,
    input  logic [DATA_W-1:0] req_freq,
    input  logic [DATA_W-1:0] req_ampph,
    output logic [3:0]        bus_fsel,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_update,
    output logic              busy,
    output logic              done
);
    logic              accept, advance, finish, hold_expire, load;
    seq_mode_e         mode_q, next_mode;
    logic [1:0]        step, next_step;
    word_ctl_t         next_ctl;
    logic [DATA_W-1:0] freq_q, ampph_q, freq_src, ampph_src;

    dps_step_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_mode    (req_mode),
        .hold_expire (hold_expire),
        .accept      (accept),
        .advance     (advance),
        .finish      (finish),
        .busy        (busy),
        .mode_q      (mode_q),
        .step        (step),
        .done        (done)
    );

    assign load = accept || advance;

    dps_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (load),
        .run     (busy),
        .expire  (hold_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q  <= '0;
            ampph_q <= '0;
        end else if (accept) begin
            freq_q  <= req_freq;
            ampph_q <= req_ampph;
        end
    end

    always_comb begin
        next_mode = accept ? seq_mode_e'(req_mode) : mode_q;
        next_step = accept ? 2'd0 : step + 2'd1;
        next_ctl  = step_ctl(next_mode, next_step);
        freq_src  = accept ? req_freq  : freq_q;
        ampph_src = accept ? req_ampph : ampph_q;
    end

    dps_word_reg #(.DATA_W(DATA_W)) u_word (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .clear_upd (finish),
        .ctl       (next_ctl),
        .freq_src  (freq_src),
        .ampph_src (ampph_src),
        .fsel      (bus_fsel),
        .data      (bus_data),
        .upd       (bus_update)
    );

    assign req_ready = !busy;

    // R5: strobe only inside a running sequence
    a_r5_upd_in_seq: assert property (@(posedge clk) disable iff (rst)
        bus_update |-> busy);

    // R5: in staged mode the strobe rises on already-settled lines
    a_r5_staged_settled: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_update) && (mode_q == SEQ_STAGED))
            |-> ($stable(bus_fsel) && $stable(bus_data)));

    // R9: idle bus is quiet
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy))
            |-> (!bus_update && $stable(bus_fsel) && $stable(bus_data)));

endmodule

// File: tb/tb_dds_par_seq.sv
module tb_dds_par_seq;
    localparam int DW   = 16;
    localparam int HOLD = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_mode;
    logic [DW-1:0] req_freq, req_ampph;
    logic          req_ready, bus_update, busy, done;
    logic [3:0]    bus_fsel;
    logic [DW-1:0] bus_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    dds_par_seq #(.DATA_W(DW), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_freq(req_freq), .req_ampph(req_ampph),
        .bus_fsel(bus_fsel), .bus_data(bus_data), .bus_update(bus_update),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected word {fsel, data, upd} for word index k
    function automatic logic [20:0] exp_word(input bit mode, input int k,
                                             input logic [DW-1:0] f,
                                             input logic [DW-1:0] a);
        if (!mode) return (k == 0) ? {4'b0010, f, 1'b0} : {4'b0101, a, 1'b1};
        case (k)
            0:       return {4'b0010, f, 1'b0};
            1:       return {4'b0101, f, 1'b0};
            2:       return {4'b0101, a, 1'b0};
            default: return {4'b0101, a, 1'b1};
        endcase
    endfunction

    task automatic accept_req(input bit mode, input logic [DW-1:0] f,
                              input logic [DW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_mode = mode; req_freq = f; req_ampph = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    // Starts right after the accepting edge; ends on the done cycle's negedge.
    task automatic expect_seq(input bit mode, input logic [DW-1:0] f,
                              input logic [DW-1:0] a, input bit idle_after,
                              input string tag);
        int nw = mode ? 4 : 2;
        logic [20:0] w, last;
        for (int j = 0; j < nw * HOLD; j++) begin
            @(negedge clk);
            w = exp_word(mode, j / HOLD, f, a);
            check({bus_fsel, bus_data, bus_update} == w, tag,
                  {11'd0, bus_fsel, bus_data, bus_update}, {11'd0, w});
            check(busy && !req_ready, "R6 busy during sequence",
                  {31'd0, busy}, 32'd1);
        end
        last = exp_word(mode, nw - 1, f, a);
        @(negedge clk);
        check(done, "R10 done after update period", {31'd0, done}, 32'd1);
        check(req_ready && !busy, "R6 ready after last hold", {31'd0, req_ready}, 32'd1);
        check({bus_fsel, bus_data, bus_update} == {last[20:1], 1'b0},
              "R9 idle keeps last word, update low",
              {11'd0, bus_fsel, bus_data, bus_update}, {11'd0, last[20:1], 1'b0});
        if (idle_after) begin
            @(negedge clk);
            check(!done, "R10 done lasts one cycle", {31'd0, done}, 32'd0);
            check({bus_fsel, bus_data, bus_update} == {last[20:1], 1'b0},
                  "R9 idle holds bus", {11'd0, bus_fsel, bus_data, bus_update},
                  {11'd0, last[20:1], 1'b0});
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(bus_fsel == 4'b0000 && bus_data == '0 && !bus_update,
              "R1 reset bus", {11'd0, bus_fsel, bus_data, bus_update}, 32'd0);
        check(!done && !busy && req_ready, "R1 reset status",
              {29'd0, done, busy, req_ready}, 32'd1);
    endtask

    task automatic t_fast;
        accept_req(1'b0, 16'h1234, 16'hABCD);
        req_valid = 1'b0;
        expect_seq(1'b0, 16'h1234, 16'hABCD, 1'b1, "R2 R4 R5 fast word");
    endtask

    task automatic t_staged;
        accept_req(1'b1, 16'h0F0F, 16'h5AA5);
        req_valid = 1'b0;
        expect_seq(1'b1, 16'h0F0F, 16'h5AA5, 1'b1, "R3 R4 R5 staged word");
    endtask

    task automatic t_input_change;
        accept_req(1'b1, 16'hC001, 16'h7E57);
        req_valid = 1'b0; req_mode = 1'b0; req_freq = 16'hDEAD; req_ampph = 16'hBEEF;
        expect_seq(1'b1, 16'hC001, 16'h7E57, 1'b1, "R8 staged unaffected by inputs");
        accept_req(1'b0, 16'h4242, 16'h9999);
        req_valid = 1'b0; req_mode = 1'b1; req_freq = 16'h1111; req_ampph = 16'h2222;
        expect_seq(1'b0, 16'h4242, 16'h9999, 1'b1, "R8 fast unaffected by inputs");
    endtask

    task automatic t_held_off;
        accept_req(1'b1, 16'hAAAA, 16'h5555);
        req_mode = 1'b0; req_freq = 16'h3C3C; req_ampph = 16'hC3C3; // valid stays high
        expect_seq(1'b1, 16'hAAAA, 16'h5555, 1'b0, "R7 first request");
        expect_seq(1'b0, 16'h3C3C, 16'hC3C3, 1'b0, "R7 held request follows");
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!done && req_ready, "R7 no extra sequence", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_mode = 1'b0; req_freq = '0; req_ampph = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_fast();
        t_staged();
        t_input_change();
        t_held_off();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule